// File: doc/BRIEF.md
# Chainable Three-Byte SPI Configuration Slave

This block is the control port of an eight-channel input device. It is an SPI slave that runs in the system clock domain. It holds one read-only byte of live channel status and four read/write bytes that set a two-bit filter mode and a two-bit delay code for each channel. The master talks to it in packets of three bytes: a control byte, then an address byte, then a data byte. Each byte is sent in its own chip-select low window. SCLK, NSS and MOSI are oversampled through a two-stage synchronizer. The system clock must be at least four times the SCLK rate.

Devices can be chained. The pass-through output of one device drives MOSI of the next device, and all devices share SCLK and NSS. A device copies every bit to its pass-through output unchanged, except the four chain-ID bits of the control byte. It decrements that field by one as the bits go through. The chain ID is carried least significant bit first, so the borrow ripples serially. The device that receives an ID of zero is the addressed one. A broadcast write updates every device in the chain.

Top module: `spi_chain_slave`

## Requirements
- R1: Each byte is sent MSB first and sampled on eight SCLK rising edges inside one NSS low window. A byte counts only when NSS rises after exactly eight edges. The bytes of a packet are control, address, data. A write whose data byte completes updates the addressed register on `mode_o`/`dly_o` after NSS rises.
- R2: Address 0x00 reads `status_i`. Address 0x01 holds the mode codes of channels 0..3 and 0x02 those of channels 4..7. Address 0x03 holds the delay codes of channels 0..3 and 0x04 those of channels 4..7. Each channel n uses bits [2n+1:2n] of `mode_o`/`dly_o`, so the lower channel sits in the less significant bits of each register.
- R3: A read of any address outside 0x00..0x04 returns 0x00. A write to 0x00 or to any address above 0x04 changes no register.
- R4: Control byte: bit 7 is broadcast, bit 6 is read (1) or write (0), bits 5:4 are reserved, and bits 3:0 carry the chain ID reversed (ID bit 0 at bit 3, ID bit 3 at bit 0). A device is selected when all four received ID bits are zero.
- R5: On `thru_o` a device reproduces MOSI bit for bit. The only exception is control-byte bits 3:0, which carry the received chain ID minus one, modulo 16, in the same reversed order.
- R6: A write with the broadcast bit set updates every device regardless of chain ID. On a read the broadcast bit has no effect, and only the selected device responds.
- R7: `miso_oe_o` is high only during the data byte of a read that selects this device. While it is high, `miso_o` presents the read byte MSB first, and the next bit appears after each SCLK falling edge.
- R8: An SCLK rising edge seen while NSS is high returns the slave to the control-byte state. A write cut short this way changes no register.
- R9: A byte that ends with a clock count other than eight abandons the packet. No register changes, and the next byte is taken as a control byte.
- R10: When NSS and SCLK rise together at the end of an eight-edge data byte, the write still commits and the slave returns to the control-byte state. When this happens at the end of a control or address byte, the packet is abandoned.
- R11: After reset all configuration registers read zero and `miso_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least four times the SCLK rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the master |
| nss_i | input | 1 | Active-low select, one low window per byte |
| mosi_i | input | 1 | Serial data in |
| status_i | input | NUM_CH | Live channel levels, read at address 0x00 |
| thru_o | output | 1 | Serial data to the next device in the chain |
| miso_o | output | 1 | Serial read data |
| miso_oe_o | output | 1 | Drive enable for the tri-state MISO pad |
| mode_o | output | 2*NUM_CH | Per-channel two-bit filter mode codes |
| dly_o | output | 2*NUM_CH | Per-channel two-bit delay codes |

## Verification
The rising edge of NSS that closes a byte and an SCLK rising edge that forces resynchronization can land in the same system-clock cycle. The bench provokes this by driving NSS and SCLK high in the same time step after the eighth bit, at the end of a data byte, an address byte and a control byte. It then judges the result at the ports. After a tail on a data byte, the written register must show the new value and a following packet must be decoded normally. After a tail on a control or address byte, no register may change, and the next packet's control byte must not be taken as data.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;
  typedef enum logic [1:0] {
    BYTE_CTRL = 2'd0,
    BYTE_ADDR = 2'd1,
    BYTE_DATA = 2'd2
  } byte_e;

  localparam int unsigned BIT_BCAST     = 7;
  localparam int unsigned BIT_READ      = 6;
  localparam int unsigned BITS_PER_BYTE = 8;
  localparam logic [7:0]  ADDR_STATUS   = 8'h00;
  localparam int unsigned ADDR_CFG_BASE = 1;

  typedef struct packed {
    logic       we;
    logic [7:0] addr;
    logic [7:0] data;
  } wr_req_t;
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     pipe_q[s] <= RST_VAL;
      else if (s == 0) pipe_q[s] <= d_i;
      else             pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_chain_frame.sv
module spi_chain_frame
  import spi_chain_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_s_i,
  input  logic       nss_s_i,
  input  logic       mosi_s_i,
  input  logic       mosi_raw_i,
  input  logic [7:0] rd_data_i,
  output logic [7:0] rd_addr_o,
  output wr_req_t    wr_o,
  output logic       thru_o,
  output logic       miso_o,
  output logic       miso_oe_o,
  output byte_e      byte_idx_o,
  output logic       sclk_rise_o,
  output logic       nss_rise_o
);
  localparam logic [3:0] CNT_FULL = 4'(BITS_PER_BYTE);
  localparam logic [3:0] CNT_OVER = 4'(BITS_PER_BYTE + 1);

  logic       sclk_d, nss_d;
  logic       sclk_rise, sclk_fall, nss_rise, nss_fall;
  byte_e      byte_q;
  logic [3:0] cnt_q;
  logic [7:0] sh_q, addr_q, tx_q;
  logic       bcast_q, read_q, sel_q, borrow_q;
  logic       cid_win;

  assign sclk_rise = sclk_s_i & ~sclk_d;
  assign sclk_fall = ~sclk_s_i & sclk_d;
  assign nss_rise  = nss_s_i & ~nss_d;
  assign nss_fall  = ~nss_s_i & nss_d;

  // chain-ID bits are control bits 3:0, i.e. the 5th..8th bit on the wire
  assign cid_win = (byte_q == BYTE_CTRL) & ~nss_s_i & (cnt_q[3:2] == 2'b01);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_d   <= 1'b0;
      nss_d    <= 1'b1;
      byte_q   <= BYTE_CTRL;
      cnt_q    <= '0;
      sh_q     <= '0;
      addr_q   <= '0;
      tx_q     <= '0;
      bcast_q  <= 1'b0;
      read_q   <= 1'b0;
      sel_q    <= 1'b0;
      borrow_q <= 1'b1;
    end else begin
      sclk_d <= sclk_s_i;
      nss_d  <= nss_s_i;
      if (nss_fall) begin
        cnt_q    <= '0;
        borrow_q <= 1'b1;
      end
      if (sclk_rise && !nss_s_i) begin
        sh_q <= {sh_q[6:0], mosi_s_i};
        if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 4'd1;
        if (cid_win) borrow_q <= borrow_q & ~mosi_s_i;
      end
      if (sclk_fall && !nss_s_i && byte_q == BYTE_DATA && cnt_q != '0)
        tx_q <= {tx_q[6:0], 1'b0};
      if (nss_rise) begin
        if (cnt_q == CNT_FULL) begin
          unique case (byte_q)
            BYTE_CTRL: begin
              bcast_q <= sh_q[BIT_BCAST];
              read_q  <= sh_q[BIT_READ];
              sel_q   <= (sh_q[3:0] == 4'd0);
              byte_q  <= BYTE_ADDR;
            end
            BYTE_ADDR: begin
              addr_q <= sh_q;
              tx_q   <= rd_data_i;
              byte_q <= BYTE_DATA;
            end
            default: byte_q <= BYTE_CTRL;
          endcase
        end else begin
          byte_q <= BYTE_CTRL;
        end
      end
      // resync wins over any advance in the same cycle
      if (sclk_rise && nss_s_i) begin
        byte_q <= BYTE_CTRL;
        cnt_q  <= '0;
      end
    end
  end

  assign rd_addr_o  = sh_q;
  assign wr_o.we    = nss_rise & (cnt_q == CNT_FULL) & (byte_q == BYTE_DATA)
                    & ~read_q & (bcast_q | sel_q);
  assign wr_o.addr  = addr_q;
  assign wr_o.data  = sh_q;
  assign thru_o     = mosi_raw_i ^ (cid_win & borrow_q);
  assign miso_o     = tx_q[7];
  assign miso_oe_o  = (byte_q == BYTE_DATA) & ~nss_s_i & read_q & sel_q;
  assign byte_idx_o = byte_q;
  assign sclk_rise_o = sclk_rise;
  assign nss_rise_o  = nss_rise;
endmodule

// File: rtl/spi_chain_regs.sv
module spi_chain_regs
  import spi_chain_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  wr_req_t              wr_i,
  input  logic [7:0]           rd_addr_i,
  input  logic [NUM_CH-1:0]    status_i,
  output logic [7:0]           rd_data_o,
  output logic [2*NUM_CH-1:0]  mode_o,
  output logic [2*NUM_CH-1:0]  dly_o,
  output logic [NUM_CH/2-1:0]  hit_o
);
  localparam int unsigned FREGS = (2 * NUM_CH) / 8;
  localparam int unsigned NREGS = 2 * FREGS;

  logic [7:0] cfg_q [NREGS];
  logic [7:0] status_ext;

  for (genvar k = 0; k < NREGS; k++) begin : g_reg
    localparam logic [7:0] REG_ADDR = 8'(ADDR_CFG_BASE + k);
    assign hit_o[k] = wr_i.we && (wr_i.addr == REG_ADDR);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cfg_q[k] <= '0;
      else if (hit_o[k]) cfg_q[k] <= wr_i.data;
    end
  end

  for (genvar k = 0; k < FREGS; k++) begin : g_out
    assign mode_o[8*k +: 8] = cfg_q[k];
    assign dly_o[8*k +: 8]  = cfg_q[FREGS + k];
  end

  always_comb begin
    status_ext = '0;
    status_ext[NUM_CH-1:0] = status_i;
    rd_data_o = '0;
    if (rd_addr_i == ADDR_STATUS) rd_data_o = status_ext;
    for (int unsigned k = 0; k < NREGS; k++)
      if (rd_addr_i == 8'(ADDR_CFG_BASE + k)) rd_data_o = cfg_q[k];
  end
endmodule

// File: rtl/spi_chain_slave.sv
module spi_chain_slave
  import spi_chain_pkg::*;
#(
  parameter int unsigned NUM_CH      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sclk_i,
  input  logic                nss_i,
  input  logic                mosi_i,
  input  logic [NUM_CH-1:0]   status_i,
  output logic                thru_o,
  output logic                miso_o,
  output logic                miso_oe_o,
  output logic [2*NUM_CH-1:0] mode_o,
  output logic [2*NUM_CH-1:0] dly_o
);
  localparam int unsigned NREGS = NUM_CH / 2;

  logic [2:0]       pins_s;
  logic             sclk_s, nss_s, mosi_s;
  logic [7:0]       rd_addr, rd_data;
  wr_req_t          wr_req;
  byte_e            byte_idx;
  logic             sclk_rise, nss_rise;
  logic [NREGS-1:0] wr_hit;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({sclk_i, nss_i, mosi_i}),
    .q_o    (pins_s)
  );
  assign {sclk_s, nss_s, mosi_s} = pins_s;

  spi_chain_frame u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_s_i    (sclk_s),
    .nss_s_i     (nss_s),
    .mosi_s_i    (mosi_s),
    .mosi_raw_i  (mosi_i),
    .rd_data_i   (rd_data),
    .rd_addr_o   (rd_addr),
    .wr_o        (wr_req),
    .thru_o      (thru_o),
    .miso_o      (miso_o),
    .miso_oe_o   (miso_oe_o),
    .byte_idx_o  (byte_idx),
    .sclk_rise_o (sclk_rise),
    .nss_rise_o  (nss_rise)
  );

  spi_chain_regs #(.NUM_CH(NUM_CH)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_req),
    .rd_addr_i (rd_addr),
    .status_i  (status_i),
    .rd_data_o (rd_data),
    .mode_o    (mode_o),
    .dly_o     (dly_o),
    .hit_o     (wr_hit)
  );
endmodule

// File: rtl/spi_chain_chk.sv
module spi_chain_chk
  import spi_chain_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                nss_i,
  input logic                mosi_i,
  input logic                thru_o,
  input logic                miso_oe_o,
  input logic [2*NUM_CH-1:0] mode_o,
  input logic [2*NUM_CH-1:0] dly_o,
  input byte_e               byte_idx,
  input logic                sclk_rise,
  input logic                nss_rise,
  input logic                nss_s,
  input logic [NUM_CH/2-1:0] wr_hit
);
  p_idx_legal_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_idx != byte_e'(2'd3));

  p_thru_copy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_idx != BYTE_CTRL) |-> (thru_o == mosi_i));

  p_resync_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_rise && nss_s) |=> (byte_idx == BYTE_CTRL));

  p_cfg_commit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({mode_o, dly_o}) |-> $past(nss_rise));

  p_oe_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nss_i && $past(nss_i) && $past(nss_i, 2) && $past(nss_i, 3)) |-> !miso_oe_o);

  p_one_target_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_hit));
endmodule

bind spi_chain_slave spi_chain_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .nss_i     (nss_i),
  .mosi_i    (mosi_i),
  .thru_o    (thru_o),
  .miso_oe_o (miso_oe_o),
  .mode_o    (mode_o),
  .dly_o     (dly_o),
  .byte_idx  (byte_idx),
  .sclk_rise (sclk_rise),
  .nss_rise  (nss_rise),
  .nss_s     (nss_s),
  .wr_hit    (wr_hit)
);

// File: tb/sim_spi_chain_slave.sv
module sim_spi_chain_slave;
  localparam int CLK_P = 10;
  localparam int HS    = 8 * CLK_P;
  localparam int NDEV  = 3;
  localparam logic [7:0] ST0 = 8'hA5, ST1 = 8'h96, ST2 = 8'hC3;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, nss = 1'b1, mosi = 1'b0;
  logic t0, t1, t2, m0, m1, m2, oe0, oe1, oe2;
  logic [15:0] mode0, mode1, mode2, dly0, dly1, dly2;
  logic [7:0] cfg [NDEV][5];
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  spi_chain_slave u0 (.clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .nss_i(nss), .mosi_i(mosi),
    .status_i(ST0), .thru_o(t0), .miso_o(m0), .miso_oe_o(oe0), .mode_o(mode0), .dly_o(dly0));
  spi_chain_slave u1 (.clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .nss_i(nss), .mosi_i(t0),
    .status_i(ST1), .thru_o(t1), .miso_o(m1), .miso_oe_o(oe1), .mode_o(mode1), .dly_o(dly1));
  spi_chain_slave u2 (.clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .nss_i(nss), .mosi_i(t1),
    .status_i(ST2), .thru_o(t2), .miso_o(m2), .miso_oe_o(oe2), .mode_o(mode2), .dly_o(dly2));

  function automatic logic [3:0] rev4(logic [3:0] x);
    return {x[0], x[1], x[2], x[3]};
  endfunction

  function automatic logic [7:0] mk(bit bc, bit rd, int cid);
    return {bc, rd, 2'b00, rev4(4'(cid))};
  endfunction

  function automatic logic [7:0] dec(logic [7:0] c, int k);
    return {c[7:4], rev4(rev4(c[3:0]) - 4'(k))};
  endfunction

  function automatic logic [7:0] st_of(int d);
    return (d == 0) ? ST0 : (d == 1) ? ST1 : ST2;
  endfunction

  function automatic logic [15:0] get_mode(int d);
    return (d == 0) ? mode0 : (d == 1) ? mode1 : mode2;
  endfunction

  function automatic logic [15:0] get_dly(int d);
    return (d == 0) ? dly0 : (d == 1) ? dly1 : dly2;
  endfunction

  function automatic logic [7:0] exp_rd(int d, logic [7:0] a);
    if (a == 8'h00) return st_of(d);
    if (a >= 8'h01 && a <= 8'h04) return cfg[d][a];
    return 8'h00;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_cfg(string tag);
    for (int d = 0; d < NDEV; d++) begin
      chk(tag, 32'(get_mode(d)), 32'({cfg[d][2], cfg[d][1]}));
      chk(tag, 32'(get_dly(d)),  32'({cfg[d][4], cfg[d][3]}));
    end
  endtask

  task automatic model_write(logic [7:0] c, logic [7:0] a, logic [7:0] v);
    for (int d = 0; d < NDEV; d++)
      if ((c[7] || rev4(c[3:0]) == 4'(d)) && a >= 8'h01 && a <= 8'h04) cfg[d][a] = v;
  endtask

  task automatic send_byte(input logic [7:0] b, input int nbits, input bit tail,
                           output logic [7:0] th0, output logic [7:0] th1,
                           output logic [7:0] rx, output logic [2:0] oe_seen,
                           output logic [2:0] oe_after);
    th0 = '0; th1 = '0; rx = '0; oe_seen = '0;
    nss = 1'b0;
    #HS;
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 8) ? b[7-i] : 1'b0;
      #HS;
      if (i < 8) begin
        th0[7-i] = t0;
        th1[7-i] = t1;
        rx[7-i]  = oe0 ? m0 : (oe1 ? m1 : m2);
      end
      oe_seen |= {oe2, oe1, oe0};
      sclk = 1'b1;
      #HS;
      sclk = 1'b0;
    end
    #HS;
    if (tail) begin
      nss = 1'b1; sclk = 1'b1;
      #HS;
      sclk = 1'b0;
      #HS;
    end else begin
      nss = 1'b1;
      #(2*HS);
    end
    oe_after = {oe2, oe1, oe0};
    mosi = 1'b0;
  endtask

  task automatic pkt(input logic [7:0] c, input logic [7:0] a, input logic [7:0] v,
                     output logic [7:0] rd);
    logic [7:0] th0, th1;
    logic [2:0] seen, after, exp_oe;
    logic [3:0] cid;
    cid = rev4(c[3:0]);
    send_byte(c, 8, 1'b0, th0, th1, rd, seen, after);
    chk("R5 ctrl thru dev0", 32'(th0), 32'(dec(c, 1)));
    chk("R5 ctrl thru dev1", 32'(th1), 32'(dec(c, 2)));
    chk("R7 no drive in ctrl byte", 32'(seen), 32'd0);
    send_byte(a, 8, 1'b0, th0, th1, rd, seen, after);
    chk("R5 addr thru", 32'(th0), 32'(a));
    chk("R7 no drive in addr byte", 32'(seen), 32'd0);
    send_byte(v, 8, 1'b0, th0, th1, rd, seen, after);
    exp_oe = (c[6] && cid < 4'(NDEV)) ? 3'(1 << cid) : 3'b000;
    chk("R7 R4 R6 data byte drivers", 32'(seen), 32'(exp_oe));
    chk("R7 released after NSS high", 32'(after), 32'd0);
    if (c[6]) begin
      if (cid < 4'(NDEV)) chk("R2 R3 read value", 32'(rd), 32'(exp_rd(int'(cid), a)));
    end else begin
      model_write(c, a, v);
      check_cfg("R1 R2 R3 write result");
    end
  endtask

  initial begin
    #(CLK_P * 190000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd, th0, th1, rx;
    logic [2:0] seen, after;
    for (int d = 0; d < NDEV; d++)
      for (int r = 0; r < 5; r++) cfg[d][r] = 8'h00;
    #2;
    #(5*CLK_P);
    chk("R11 reset oe", 32'({oe2, oe1, oe0}), 32'd0);
    check_cfg("R11 reset cfg");
    rst_n = 1'b1;
    #(4*CLK_P);

    // chain-ID walk: every ID through the chain, reads of status
    for (int c = 0; c < 16; c++) pkt(mk(0, 1, c), 8'h00, 8'h00, rd);

    // per-device write / read sweep over the whole address byte range used
    for (int a = 0; a < 8; a++)
      for (int t = 0; t < NDEV; t++) begin
        pkt(mk(0, 0, t), 8'(a), 8'(a*37 + t*101 + 1) ^ 8'h5A, rd);
        for (int r = 0; r < NDEV; r++) pkt(mk(0, 1, r), 8'(a), 8'h00, rd);
      end
    pkt(mk(0, 1, 1), 8'hFF, 8'h00, rd);  // R3 far-out address

    // R6 broadcast writes with a non-matching ID, broadcast reads
    for (int a = 1; a <= 4; a++) pkt(mk(1, 0, 9), 8'(a), 8'(8'h11 * a) ^ 8'hF0, rd);
    pkt(mk(1, 1, 2), 8'h03, 8'h00, rd);
    pkt(mk(1, 1, 6), 8'h03, 8'h00, rd);

    // R9 short and long data bytes
    send_byte(mk(0, 0, 1), 8, 1'b0, th0, th1, rx, seen, after);
    send_byte(8'h02, 8, 1'b0, th0, th1, rx, seen, after);
    send_byte(8'h3C, 7, 1'b0, th0, th1, rx, seen, after);
    check_cfg("R9 seven-clock data byte");
    pkt(mk(0, 0, 1), 8'h02, 8'h5D, rd);
    chk("R9 recovery write", 32'(mode1[15:8]), 32'h5D);
    send_byte(mk(0, 0, 1), 8, 1'b0, th0, th1, rx, seen, after);
    send_byte(8'h02, 8, 1'b0, th0, th1, rx, seen, after);
    send_byte(8'hE1, 9, 1'b0, th0, th1, rx, seen, after);
    check_cfg("R9 nine-clock data byte");
    send_byte(mk(0, 0, 0), 9, 1'b0, th0, th1, rx, seen, after);
    pkt(mk(0, 0, 0), 8'h01, 8'h9A, rd);
    chk("R9 long ctrl byte abandoned", 32'(mode0[7:0]), 32'h9A);

    // R8 resync between address and data byte
    send_byte(mk(0, 0, 0), 8, 1'b0, th0, th1, rx, seen, after);
    send_byte(8'h01, 8, 1'b0, th0, th1, rx, seen, after);
    sclk = 1'b1; #HS; sclk = 1'b0; #HS;
    pkt(mk(0, 0, 0), 8'h03, 8'h77, rd);
    chk("R8 target kept", 32'(mode0[7:0]), 32'h9A);
    chk("R8 next packet decoded", 32'(dly0[7:0]), 32'h77);

    // R10 NSS and SCLK rising together
    send_byte(mk(0, 0, 2), 8, 1'b0, th0, th1, rx, seen, after);
    send_byte(8'h04, 8, 1'b0, th0, th1, rx, seen, after);
    send_byte(8'h6B, 8, 1'b1, th0, th1, rx, seen, after);
    model_write(mk(0, 0, 2), 8'h04, 8'h6B);
    check_cfg("R10 data tail commits");
    pkt(mk(0, 1, 2), 8'h04, 8'h00, rd);
    send_byte(mk(0, 0, 0), 8, 1'b0, th0, th1, rx, seen, after);
    send_byte(8'h01, 8, 1'b1, th0, th1, rx, seen, after);
    pkt(mk(0, 0, 0), 8'h03, 8'h29, rd);
    chk("R10 addr tail abandons", 32'(mode0[7:0]), 32'h9A);
    send_byte(mk(0, 0, 1), 8, 1'b1, th0, th1, rx, seen, after);
    pkt(mk(0, 0, 1), 8'h01, 8'hB4, rd);
    chk("R10 ctrl tail abandons", 32'(mode1[7:0]), 32'hB4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule